// File: doc/BRIEF.md
# Serial Character Transmitter with Flow Gating

This block turns parallel characters into an asynchronous serial frame. A frame is a start bit, then 7, 8 or 9 data bits with the least significant bit first, then one stop bit. A two-bit length code picks the data width. The bit rate comes from a single-cycle `baud_tick` pulse made by an external divider. Each bit lasts exactly one tick interval.

Characters enter through a valid/ready handshake. A clear-to-send style input, `cts_block`, holds back new frames. It never cuts a frame that has already started. A one-cycle `brk_req` pulse asks for a break frame: the start bit and every data slot are held at the active (zero) level, then two stop bits follow. A pending break wins over any character offered at the same boundary.

`drv_en` tells an external half-duplex transceiver to drive the line while a frame is on the wire. `inv_pol` inverts the whole line, including the idle level. Dropping `tx_en` aborts any frame and parks the line at its idle level.

Top module: `uart_tx_ctl`

## Requirements
- R1: After reset with `inv_pol` low and `tx_en` low, `ser_out` is 1, `drv_en` is 0, `busy` is 0 and `char_ready` is 0.
- R2: The data width is taken from `len_mode` when a frame is accepted. The codes are:
  - 2'b10 selects 7 bits.
  - 2'b00 selects 8 bits.
  - 2'b01 selects 9 bits.
  - 2'b11 (undefined) behaves as 8 bits.
- R3: With normal polarity, a frame is laid out as follows, and each bit lasts one `baud_tick` interval:
  - one start bit at 0;
  - the data bits, `char_data[0]` first;
  - one stop bit at 1.
- R4: When `inv_pol` is 1, every line level is inverted: start, data, stop and idle.
- R5: While enabled with nothing to send, `ser_out` rests at the idle level (1 with normal polarity) and `drv_en` is 0.
- R6: A break frame is a start bit plus as many data slots as the current width, all at 0, followed by exactly two stop bits at 1.
- R7: While `cts_block` is 1, no new frame (character or break) starts. A frame already in progress runs to its last stop bit.
- R8: `drv_en` and `busy` are 1 from the start bit through the last stop bit. `drv_en` returns to 0 once the line is idle.
- R9: When `tx_en` is 0, `ser_out` takes the idle level (`!inv_pol`) and `drv_en` and `busy` go to 0 on the next clock. The aborted frame is not resumed when the block is re-enabled.
- R10: A break request takes priority over a character offered in the same cycle. The break frame goes out first and the character follows.
- R11: `char_ready` is 1 only when the block is idle, `tx_en` is 1, `cts_block` is 0 and no break is requested or pending. After an accepted character, `char_ready` is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low aborts and parks the line |
| len_mode | input | 2 | Data length code (10=7, 00=8, 01=9, 11=8 bits) |
| inv_pol | input | 1 | Invert all line levels |
| cts_block | input | 1 | High holds back new frames |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| char_data | input | DATA_W | Character to send, LSB first |
| char_valid | input | 1 | Character offered |
| char_ready | output | 1 | Character accepted when high with `char_valid` |
| brk_req | input | 1 | Pulse requesting one break frame |
| ser_out | output | 1 | Serial line (registered) |
| drv_en | output | 1 | External transceiver drive enable (registered) |
| busy | output | 1 | Frame in flight (registered) |

## Verification
The hardest situation to reach from the ports is a collision at a frame boundary. This covers a break request and a character arriving in the same cycle. It also covers `cts_block` rising part-way through a frame while the next character is already being offered. The stimulus raises `cts_block` right after a chosen data bit has been sampled, and holds `char_valid` high across the whole stall. It then checks that the frame finishes, that the line stays idle while `cts_block` is high, and that the waiting character leaves only after release. The priority case presents `brk_req` and `char_valid` on the same negative edge, then checks bit by bit that the zero-filled break with its two stop bits goes out before the character.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,    // accepted, waiting for the first tick so every bit is a full period
    S_START,
    S_DATA,
    S_STOP
  } tx_state_e;

  localparam logic [1:0] LEN_CODE_7 = 2'b10;
  localparam logic [1:0] LEN_CODE_8 = 2'b00;
  localparam logic [1:0] LEN_CODE_9 = 2'b01;
endpackage

// File: rtl/utx_len_dec.sv
module utx_len_dec #(
  parameter int CNT_W = 4
) (
  input  logic [1:0]       code,
  output logic [CNT_W-1:0] nbits
);
  import utx_pkg::*;

  always_comb begin
    case (code)
      LEN_CODE_7: nbits = CNT_W'(7);
      LEN_CODE_9: nbits = CNT_W'(9);
      default:    nbits = CNT_W'(8);  // 8-bit code and the undefined code
    endcase
  end
endmodule

// File: rtl/utx_frame_fsm.sv
module utx_frame_fsm #(
  parameter int DATA_W = 9,
  parameter int CNT_W  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                cts_block,
  input  logic                baud_tick,
  input  logic [CNT_W-1:0]    nbits,
  input  logic [DATA_W-1:0]   data_in,
  input  logic                data_valid,
  output logic                data_ready,
  input  logic                brk_req,
  output utx_pkg::tx_state_e  state,
  output logic                line_lvl
);
  import utx_pkg::*;

  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              is_brk;
  logic              extra_stop;
  logic              brk_pend;

  // Break (requested now or pending) blocks the character path.
  assign data_ready = en && !cts_block && !brk_pend && !brk_req && (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state      <= S_IDLE;
      shreg      <= '0;
      bitcnt     <= '0;
      is_brk     <= 1'b0;
      extra_stop <= 1'b0;
      brk_pend   <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (brk_pend && !cts_block) begin
            brk_pend <= 1'b0;
            is_brk   <= 1'b1;
            shreg    <= '0;
            bitcnt   <= nbits - 1'b1;
            state    <= S_ARM;
          end else if (data_valid && data_ready) begin
            is_brk <= 1'b0;
            shreg  <= data_in;
            bitcnt <= nbits - 1'b1;
            state  <= S_ARM;
          end
        end
        S_ARM: begin
          if (baud_tick) state <= S_START;
        end
        S_START: begin
          if (baud_tick) state <= S_DATA;
        end
        S_DATA: begin
          if (baud_tick) begin
            shreg <= shreg >> 1;
            if (bitcnt == '0) begin
              extra_stop <= is_brk;
              state      <= S_STOP;
            end else begin
              bitcnt <= bitcnt - 1'b1;
            end
          end
        end
        S_STOP: begin
          if (baud_tick) begin
            if (extra_stop) extra_stop <= 1'b0;
            else            state      <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (brk_req) brk_pend <= 1'b1;
    end
  end

  always_comb begin
    case (state)
      S_START: line_lvl = 1'b0;
      S_DATA:  line_lvl = shreg[0];
      default: line_lvl = 1'b1;
    endcase
  end
endmodule

// File: rtl/utx_line_drv.sv
module utx_line_drv (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               inv_pol,
  input  utx_pkg::tx_state_e state,
  input  logic               line_lvl,
  output logic               ser_out,
  output logic               drv_en,
  output logic               busy
);
  import utx_pkg::*;

  logic on_wire;
  assign on_wire = (state == S_START) || (state == S_DATA) || (state == S_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_out <= ~inv_pol;
      drv_en  <= 1'b0;
      busy    <= 1'b0;
    end else begin
      ser_out <= (en ? line_lvl : 1'b1) ^ inv_pol;
      drv_en  <= en && on_wire;
      busy    <= en && (state != S_IDLE);
    end
  end
endmodule

// File: rtl/uart_tx_ctl.sv
module uart_tx_ctl #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic [1:0]        len_mode,
  input  logic              inv_pol,
  input  logic              cts_block,
  input  logic              baud_tick,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_valid,
  output logic              char_ready,
  input  logic              brk_req,
  output logic              ser_out,
  output logic              drv_en,
  output logic              busy
);
  import utx_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic [CNT_W-1:0] nbits;
  tx_state_e        state;
  logic             line_lvl;

  utx_len_dec #(.CNT_W(CNT_W)) u_len (
    .code  (len_mode),
    .nbits (nbits)
  );

  utx_frame_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en         (tx_en),
    .cts_block  (cts_block),
    .baud_tick  (baud_tick),
    .nbits      (nbits),
    .data_in    (char_data),
    .data_valid (char_valid),
    .data_ready (char_ready),
    .brk_req    (brk_req),
    .state      (state),
    .line_lvl   (line_lvl)
  );

  utx_line_drv u_drv (
    .clk      (clk),
    .rst      (rst),
    .en       (tx_en),
    .inv_pol  (inv_pol),
    .state    (state),
    .line_lvl (line_lvl),
    .ser_out  (ser_out),
    .drv_en   (drv_en),
    .busy     (busy)
  );
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic clk,
  input logic rst,
  input logic tx_en,
  input logic inv_pol,
  input logic cts_block,
  input logic char_valid,
  input logic char_ready,
  input logic ser_out,
  input logic drv_en,
  input logic busy
);
  AST_OFF_PARKS_LINE: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (ser_out == !$past(inv_pol))); // R9

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!drv_en && !busy)); // R9

  AST_CTS_GATES_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !$past(cts_block, 2)); // R7

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
    (char_ready && char_valid) |=> !char_ready); // R11

  AST_DRIVE_MEANS_BUSY: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> busy); // R8

  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    ($rose(drv_en) && $stable(inv_pol)) |-> (ser_out == inv_pol)); // R3
endmodule

bind uart_tx_ctl utx_checker u_chk (.*);

// File: tb/sim_uart_tx_ctl.sv
module sim_uart_tx_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic [1:0] len_mode = 2'b00;
  logic       inv_pol = 1'b0;
  logic       cts_block = 1'b0;
  logic       baud_tick;
  logic [8:0] char_data = '0;
  logic       char_valid = 1'b0;
  logic       char_ready;
  logic       brk_req = 1'b0;
  logic       ser_out;
  logic       drv_en;
  logic       busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  // Baud tick every 8 clocks.
  logic [2:0] tcnt;
  always_ff @(posedge clk) begin
    if (rst) tcnt <= '0;
    else     tcnt <= tcnt + 3'd1;
  end
  assign baud_tick = (tcnt == 3'd7);

  uart_tx_ctl #(.DATA_W(9)) u0 (
    .clk(clk), .rst(rst), .tx_en(tx_en), .len_mode(len_mode), .inv_pol(inv_pol),
    .cts_block(cts_block), .baud_tick(baud_tick), .char_data(char_data),
    .char_valid(char_valid), .char_ready(char_ready), .brk_req(brk_req),
    .ser_out(ser_out), .drv_en(drv_en), .busy(busy)
  );

  // Vector fields: {len_mode[15:14], inv[13], expected width[12:9], data[8:0]}
  localparam logic [15:0] VEC [0:7] = '{
    {2'b10, 1'b0, 4'd7, 9'h055},
    {2'b00, 1'b0, 4'd8, 9'h0A5},
    {2'b01, 1'b0, 4'd9, 9'h0C3},
    {2'b11, 1'b0, 4'd8, 9'h0BC},
    {2'b00, 1'b1, 4'd8, 9'h0F0},
    {2'b10, 1'b1, 4'd7, 9'h100},
    {2'b01, 1'b1, 4'd9, 9'h12D},
    {2'b00, 1'b0, 4'd8, 9'h000}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // Called at a negative edge.
  task automatic start_char(input logic [8:0] d);
    char_data  = d;
    char_valid = 1'b1;
    #1;
    while (!char_ready) @(negedge clk);
    @(negedge clk);
    char_valid = 1'b0;
  endtask

  task automatic check_frame(input int nb, input logic inv, input logic [8:0] d, input int nstop,
                             input bit tail_idle, input int cts_bit, input string tag);
    int w = 0;
    while (ser_out !== inv && w < 400) begin
      @(negedge clk);
      w++;
    end
    chk(w < 400, {tag, " R3 start edge seen"}, 16'(w), 16'd0);
    repeat (4) @(negedge clk);
    chk(ser_out == inv, {tag, " R3 start level"}, 16'(ser_out), 16'(inv));
    chk(drv_en && busy, {tag, " R8 drv_en/busy in start"}, {14'd0, drv_en, busy}, 16'h3);
    chk(!char_ready, {tag, " R11 ready low in frame"}, 16'(char_ready), 16'd0);
    for (int i = 0; i < nb; i++) begin
      repeat (8) @(negedge clk);
      chk(ser_out == (d[i] ^ inv), {tag, " R2 R3 R4 data bit"}, 16'(ser_out), 16'(d[i] ^ inv));
      chk(drv_en, {tag, " R8 drv_en in data"}, 16'(drv_en), 16'd1);
      if (i == cts_bit) cts_block = 1'b1;
    end
    for (int s = 0; s < nstop; s++) begin
      repeat (8) @(negedge clk);
      chk(ser_out == !inv, {tag, " R3 R6 stop level"}, 16'(ser_out), 16'(!inv));
      chk(drv_en && busy, {tag, " R6 R8 drv_en in stop"}, {14'd0, drv_en, busy}, 16'h3);
    end
    if (tail_idle) begin
      repeat (8) @(negedge clk);
      chk(!drv_en && ser_out == !inv, {tag, " R5 R8 idle after frame"},
          {14'd0, drv_en, ser_out}, {14'd0, 1'b0, !inv});
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ser_out == 1'b1 && !drv_en && !busy && !char_ready, "R1 reset outputs",
        {12'd0, ser_out, drv_en, busy, char_ready}, 16'h8);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!char_ready, "R11 ready low while disabled", 16'(char_ready), 16'd0);
    tx_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(ser_out == 1'b1 && !drv_en, "R5 idle line when enabled",
        {14'd0, ser_out, drv_en}, 16'h2);
    chk(char_ready, "R11 ready when idle", 16'(char_ready), 16'd1);

    // Table walk: length codes, bit order, polarity
    foreach (VEC[k]) begin
      len_mode = VEC[k][15:14];
      inv_pol  = VEC[k][13];
      repeat (12) @(negedge clk);
      chk(ser_out == !inv_pol, "R4 R5 idle level per polarity", 16'(ser_out), 16'(!inv_pol));
      start_char(VEC[k][8:0]);
      check_frame(int'(VEC[k][12:9]), VEC[k][13], VEC[k][8:0], 1, 1'b1, -1, "vector");
    end

    // R6 break frames
    inv_pol = 1'b0;
    len_mode = 2'b00;
    repeat (10) @(negedge clk);
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    check_frame(8, 1'b0, 9'h000, 2, 1'b1, -1, "R6 break 8");
    len_mode = 2'b10;
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    check_frame(7, 1'b0, 9'h000, 2, 1'b1, -1, "R6 break 7");

    // R10 break beats a simultaneous character
    len_mode = 2'b00;
    char_data = 9'h05A;
    char_valid = 1'b1;
    brk_req = 1'b1;
    @(negedge clk);
    brk_req = 1'b0;
    check_frame(8, 1'b0, 9'h000, 2, 1'b0, -1, "R10 break first");
    start_char(9'h05A);
    check_frame(8, 1'b0, 9'h05A, 1, 1'b1, -1, "R10 char after break");

    // R7 CTS holds back a new frame while idle
    cts_block = 1'b1;
    char_data = 9'h033;
    char_valid = 1'b1;
    repeat (40) @(negedge clk);
    chk(ser_out && !drv_en && !busy && !char_ready, "R7 R11 no start while blocked",
        {12'd0, ser_out, drv_en, busy, char_ready}, 16'h8);
    cts_block = 1'b0;
    start_char(9'h033);
    check_frame(8, 1'b0, 9'h033, 1, 1'b1, -1, "R7 after release");

    // R7 CTS mid-frame: current frame finishes, next one waits
    start_char(9'h0C6);
    check_frame(8, 1'b0, 9'h0C6, 1, 1'b1, 2, "R7 finish in progress");
    char_data = 9'h011;
    char_valid = 1'b1;
    repeat (40) @(negedge clk);
    chk(ser_out && !drv_en && !busy, "R7 stalled after frame",
        {13'd0, ser_out, drv_en, busy}, 16'h4);
    cts_block = 1'b0;
    start_char(9'h011);
    check_frame(8, 1'b0, 9'h011, 1, 1'b1, -1, "R7 waiting char sent");

    // R9 disable aborts a frame
    inv_pol = 1'b1;
    repeat (10) @(negedge clk);
    start_char(9'h0FF);
    while (ser_out !== 1'b1) @(negedge clk);
    repeat (20) @(negedge clk);
    tx_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(ser_out == 1'b0 && !drv_en && !busy && !char_ready, "R9 abort parks line",
        {12'd0, ser_out, drv_en, busy, char_ready}, 16'h0);
    tx_en = 1'b1;
    repeat (40) @(negedge clk);
    chk(ser_out == 1'b0 && !drv_en && !busy, "R9 no resume after enable",
        {13'd0, ser_out, drv_en, busy}, 16'h0);
    chk(char_ready, "R11 ready after re-enable", 16'(char_ready), 16'd1);

    report();
  end
endmodule